// File: doc/BRIEF.md
# Byte-Interleaved 4:2:2 Video Output Formatter

This block takes 4:2:2 pixel pairs (two luma samples with one shared pair of colour-difference samples) from an internal pixel pipeline. It serialises each pair onto a byte-wide digital video bus, red-difference byte first. Next to the data it drives a video output clock, which is nominally 27 MHz with a period of about 37 ns. It also drives horizontal and vertical sync outputs. The sync pulses come in from a separate timing generator. This block only retimes them so they line up with the data bytes, and applies the polarity that configuration selects.

The block runs on one internal clock at twice the output clock rate. The output clock is made by toggling a register on every internal cycle. In interlaced mode, one byte leaves per output clock period, on the active edge only. In progressive mode, a byte leaves on both edges of the output clock. All outputs move within one internal cycle of the output clock edge, so a receiver should sample on the opposite edge.

Pairs are accepted through a ready/valid handshake, and only when the byte sequencer is about to start a new pair. When no pair is offered there, the bus carries a blanking pair instead.

Top module: `yfmt_video_out`

## Requirements
- R1: While `rst` is high, `vdat_o` is 0x80, `vclk_o` equals `cfg_clk_invert`, `hsync_o` equals `cfg_hs_active_low`, `vsync_o` equals `cfg_vs_active_low`, and `pix_ready` is low.
- R2: An accepted pair leaves in four consecutive byte launches, in the order Cr, Y0, Cb, Y1. The Cr byte appears in the cycle after the accepting edge.
- R3: With `cfg_progressive` low, a byte is launched on every second `clk` edge, namely the edges after which the output clock is at its active (high, before inversion) level. `vdat_o`, `hsync_o` and `vsync_o` hold their values across the other edges.
- R4: With `cfg_progressive` high, a byte is launched on every `clk` edge, so data changes at both the rising and the falling edge of `vclk_o`.
- R5: After reset, `vclk_o` toggles on every `clk` edge. Its first value after reset is the active level: 1 XOR `cfg_clk_invert`.
- R6: `pix_ready` is high only in a cycle whose next edge launches a byte, and only when that byte is the first byte of a pair (launch index 0 mod 4). A pair is accepted when `pix_valid` and `pix_ready` are both high.
- R7: If no pair is accepted at the first byte of a pair, the four launches carry the blanking codes 0x80, 0x10, 0x80, 0x10. That is 0x80 on colour-difference slots and 0x10 on luma slots.
- R8: At each byte launch, `hsync_o` takes `hsync_in` XOR `cfg_hs_active_low`, and `vsync_o` takes `vsync_in` XOR `cfg_vs_active_low`, both sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the output clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_progressive | input | 1 | 1: launch on both output clock edges; 0: one launch per period |
| cfg_clk_invert | input | 1 | Inverts `vclk_o` |
| cfg_hs_active_low | input | 1 | 1: horizontal sync output is active low |
| cfg_vs_active_low | input | 1 | 1: vertical sync output is active low |
| pix_valid | input | 1 | A pixel pair is offered |
| pix_ready | output | 1 | The offered pair is taken at the next edge |
| pix_y0 | input | 8 | First luma sample |
| pix_y1 | input | 8 | Second luma sample |
| pix_cb | input | 8 | Blue-difference sample |
| pix_cr | input | 8 | Red-difference sample |
| hsync_in | input | 1 | Horizontal sync from the timing generator, active high |
| vsync_in | input | 1 | Vertical sync from the timing generator, active high |
| vclk_o | output | 1 | Video output clock |
| vdat_o | output | 8 | Byte-wide video data |
| hsync_o | output | 1 | Retimed horizontal sync |
| vsync_o | output | 1 | Retimed vertical sync |

## Verification
On every cycle, the assertions check the following:
- the output clock toggles;
- interlaced data and sync hold still between launches;
- in progressive mode, sync follows its input with the selected polarity;
- an accepted pair always leads with its Cr byte;
- a missing pair puts the luma blanking code in the second slot.

Only the bench scenarios show the following:
- the full four-byte order across back-to-back and gapped pairs;
- the handshake landing on the first slot of a pair in both modes and with either clock polarity;
- the reset levels under each configuration;
- that nothing accepted is lost.

// File: rtl/yfmt_pkg.sv
package yfmt_pkg;

  // Byte slots of one pixel pair, in launch order.
  typedef enum logic [1:0] {
    SLOT_CR = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_CB = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_e;

  function automatic slot_e slot_next(input slot_e s);
    return slot_e'(s + 2'd1);
  endfunction

endpackage

// File: rtl/yfmt_clkgen.sv
module yfmt_clkgen (
  input  logic clk,
  input  logic rst,
  input  logic cfg_progressive,
  input  logic cfg_clk_invert,
  output logic step,
  output logic vclk_o
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      vclk_o  <= cfg_clk_invert;
    end else begin
      phase_q <= ~phase_q;
      vclk_o  <= (~phase_q) ^ cfg_clk_invert;
    end
  end

  // A launch happens on edges that take the phase high (interlaced),
  // or on every edge (progressive).
  assign step = cfg_progressive | ~phase_q;

  // R5: output clock toggles on every edge once out of reset
  p_vclk_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vclk_o != $past(vclk_o)))
    else $error("vclk_o did not toggle");

endmodule

// File: rtl/yfmt_sequencer.sv
module yfmt_sequencer
  import yfmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_y0,
  input  logic [DATA_W-1:0] pix_y1,
  input  logic [DATA_W-1:0] pix_cb,
  input  logic [DATA_W-1:0] pix_cr,
  output logic [DATA_W-1:0] vdat_o
);

  localparam logic [DATA_W-1:0] BLANK_C = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] BLANK_Y = DATA_W'(1) << (DATA_W - 4);
  localparam int                NSLOT   = 4;

  slot_e             slot_q;
  logic              have_pair_q;
  logic [DATA_W-1:0] hold_q [NSLOT];
  logic              take;
  logic [DATA_W-1:0] next_byte;

  assign pix_ready = step & (slot_q == SLOT_CR) & ~rst;
  assign take      = pix_valid & pix_ready;

  always_comb begin
    if (slot_q == SLOT_CR)
      next_byte = take ? pix_cr : BLANK_C;
    else if (have_pair_q)
      next_byte = hold_q[slot_q];
    else
      next_byte = slot_q[0] ? BLANK_Y : BLANK_C;
  end

  // Pair storage: no reset needed, read only while have_pair_q is set.
  always_ff @(posedge clk) begin
    if (take) begin
      hold_q[SLOT_CR] <= pix_cr;
      hold_q[SLOT_Y0] <= pix_y0;
      hold_q[SLOT_CB] <= pix_cb;
      hold_q[SLOT_Y1] <= pix_y1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q      <= SLOT_CR;
      have_pair_q <= 1'b0;
      vdat_o      <= BLANK_C;
    end else if (step) begin
      slot_q <= slot_next(slot_q);
      vdat_o <= next_byte;
      if (slot_q == SLOT_CR)
        have_pair_q <= take;
    end
  end

  // R2: an accepted pair leads with its Cr byte
  p_cr_first_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_ready) |=> (vdat_o == $past(pix_cr)))
    else $error("first byte of accepted pair is not Cr");

  // R7: with no pair, the luma slot after Cr carries the luma blanking code
  p_blank_luma_r7: assert property (@(posedge clk) disable iff (rst)
    (step && slot_q == SLOT_Y0 && !have_pair_q) |=> (vdat_o == BLANK_Y))
    else $error("luma blanking code missing");

endmodule

// File: rtl/yfmt_sync_retime.sv
module yfmt_sync_retime #(
  parameter int NUM_SYNC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic [NUM_SYNC-1:0] sync_in,
  input  logic [NUM_SYNC-1:0] active_low,
  output logic [NUM_SYNC-1:0] sync_o
);

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        sync_o[i] <= active_low[i];
      else if (step)
        sync_o[i] <= sync_in[i] ^ active_low[i];
    end
  end

endmodule

// File: rtl/yfmt_video_out.sv
module yfmt_video_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_progressive,
  input  logic              cfg_clk_invert,
  input  logic              cfg_hs_active_low,
  input  logic              cfg_vs_active_low,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_y0,
  input  logic [DATA_W-1:0] pix_y1,
  input  logic [DATA_W-1:0] pix_cb,
  input  logic [DATA_W-1:0] pix_cr,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic              vclk_o,
  output logic [DATA_W-1:0] vdat_o,
  output logic              hsync_o,
  output logic              vsync_o
);

  localparam int NUM_SYNC = 2;

  logic                step;
  logic [NUM_SYNC-1:0] sync_out;

  yfmt_clkgen i_clkgen (
    .clk             (clk),
    .rst             (rst),
    .cfg_progressive (cfg_progressive),
    .cfg_clk_invert  (cfg_clk_invert),
    .step            (step),
    .vclk_o          (vclk_o)
  );

  yfmt_sequencer #(.DATA_W(DATA_W)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_y0    (pix_y0),
    .pix_y1    (pix_y1),
    .pix_cb    (pix_cb),
    .pix_cr    (pix_cr),
    .vdat_o    (vdat_o)
  );

  yfmt_sync_retime #(.NUM_SYNC(NUM_SYNC)) i_sync (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .sync_in    ({vsync_in, hsync_in}),
    .active_low ({cfg_vs_active_low, cfg_hs_active_low}),
    .sync_o     (sync_out)
  );

  assign hsync_o = sync_out[0];
  assign vsync_o = sync_out[1];

  // R3: interlaced outputs hold across edges that leave the clock inactive
  p_hold_between_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !cfg_progressive && (vclk_o == cfg_clk_invert))
      |-> ($stable(vdat_o) && $stable(hsync_o) && $stable(vsync_o)))
    else $error("interlaced output moved off the active edge");

  // R8: progressive sync follows its input with the chosen polarity
  p_sync_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cfg_progressive)
      |-> (hsync_o == ($past(hsync_in) ^ cfg_hs_active_low)) &&
          (vsync_o == ($past(vsync_in) ^ cfg_vs_active_low)))
    else $error("sync output mismatch");

endmodule

// File: tb/test_yfmt_video_out.sv
module test_yfmt_video_out;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_progressive = 1'b0, cfg_clk_invert = 1'b0;
  logic       cfg_hs_active_low = 1'b0, cfg_vs_active_low = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_y0 = '0, pix_y1 = '0, pix_cb = '0, pix_cr = '0;
  logic       hsync_in = 1'b0, vsync_in = 1'b0;
  logic       vclk_o, hsync_o, vsync_o;
  logic [7:0] vdat_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic exp_ph = 1'b0;
  int   n_launch = 0;
  logic [7:0] last_dat = 8'h80;
  logic last_hs = 1'b0, last_vs = 1'b0;

  always #4 clk = ~clk;

  yfmt_video_out i_yfmt_video_out (
    .clk(clk), .rst(rst),
    .cfg_progressive(cfg_progressive), .cfg_clk_invert(cfg_clk_invert),
    .cfg_hs_active_low(cfg_hs_active_low), .cfg_vs_active_low(cfg_vs_active_low),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_y0(pix_y0), .pix_y1(pix_y1), .pix_cb(pix_cb), .pix_cr(pix_cr),
    .hsync_in(hsync_in), .vsync_in(vsync_in),
    .vclk_o(vclk_o), .vdat_o(vdat_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops the scoreboard at each expected launch, 2 ns after the edge.
  always @(posedge clk) begin
    automatic logic r = rst;
    #2;
    if (r) begin
      exp_ph = 1'b0;
      n_launch = 0;
    end else begin
      exp_ph = ~exp_ph;
      check(vclk_o === (exp_ph ^ cfg_clk_invert), "R5 vclk", vclk_o, exp_ph ^ cfg_clk_invert);
      if (cfg_progressive || exp_ph) begin
        automatic logic [7:0] e;
        automatic string tag = cfg_progressive ? "R4/R2" : "R3/R2";
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else begin
          e = (n_launch % 2 == 0) ? 8'h80 : 8'h10;
          tag = "R7 blank";
        end
        check(vdat_o === e, tag, vdat_o, e);
        check(hsync_o === (hsync_in ^ cfg_hs_active_low), "R8 hsync", hsync_o,
              hsync_in ^ cfg_hs_active_low);
        check(vsync_o === (vsync_in ^ cfg_vs_active_low), "R8 vsync", vsync_o,
              vsync_in ^ cfg_vs_active_low);
        n_launch++;
        last_dat = vdat_o;
        last_hs = hsync_o;
        last_vs = vsync_o;
      end else begin
        check(vdat_o === last_dat, "R3 hold data", vdat_o, last_dat);
        check(hsync_o === last_hs && vsync_o === last_vs, "R3 hold sync",
              {hsync_o, vsync_o}, {last_hs, last_vs});
      end
    end
  end

  task automatic do_reset(input logic prog, input logic inv, input logic hsl, input logic vsl);
    @(negedge clk);
    rst = 1'b1;
    pix_valid = 1'b0;
    cfg_progressive = prog;
    cfg_clk_invert = inv;
    cfg_hs_active_low = hsl;
    cfg_vs_active_low = vsl;
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(vdat_o === 8'h80, "R1 vdat", vdat_o, 8'h80);
    check(vclk_o === inv, "R1 vclk", vclk_o, inv);
    check(hsync_o === hsl && vsync_o === vsl, "R1 sync", {hsync_o, vsync_o}, {hsl, vsl});
    check(pix_ready === 1'b0, "R1 ready", pix_ready, 0);
    last_dat = 8'h80;
    last_hs = hsl;
    last_vs = vsl;
    rst = 1'b0;
  endtask

  // Driver: offers one pair and pushes its bytes when the handshake completes.
  task automatic send_pair(input logic [7:0] y0, input logic [7:0] y1,
                           input logic [7:0] cb, input logic [7:0] cr,
                           input logic hs, input logic vs);
    pix_valid = 1'b1;
    pix_y0 = y0; pix_y1 = y1; pix_cb = cb; pix_cr = cr;
    hsync_in = hs; vsync_in = vs;
    #1;
    while (!pix_ready) begin
      @(negedge clk);
      #1;
    end
    check((n_launch % 4 == 0) && (cfg_progressive || !exp_ph), "R6 ready slot",
          n_launch % 4, 0);
    exp_q.push_back(cr);
    exp_q.push_back(y0);
    exp_q.push_back(cb);
    exp_q.push_back(y1);
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic idle(input int n, input logic hs, input logic vs);
    pix_valid = 1'b0;
    hsync_in = hs;
    vsync_in = vs;
    repeat (n) @(negedge clk);
  endtask

  task automatic scenario(input int seed);
    for (int i = 0; i < 4; i++)
      send_pair(8'(seed + 16 * i + 1), 8'(seed + 16 * i + 2), 8'(seed + 16 * i + 3),
                8'(seed + 16 * i + 4), i[0], i[1]);
    idle(11, 1'b1, 1'b0);
    for (int i = 0; i < 2; i++)
      send_pair(8'(seed ^ (8'h5A + i)), 8'(seed ^ (8'hA5 - i)), 8'(8'hC3 + i), 8'(8'h3C - i),
                ~i[0], i[0]);
    idle(9, 1'b0, 1'b1);
    send_pair(8'hFF, 8'h00, 8'h80, 8'h10, 1'b0, 1'b0);
    idle(24, 1'b0, 1'b0);
    check(exp_q.size() == 0, "R6 drained", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    scenario(8'h20);
    do_reset(1'b0, 1'b1, 1'b1, 1'b0);
    scenario(8'h47);
    do_reset(1'b1, 1'b1, 1'b1, 1'b0);
    scenario(8'h91);
    do_reset(1'b1, 1'b0, 1'b0, 1'b1);
    scenario(8'h0E);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule